// File: doc/BRIEF.md
# Two-Trigger ADC Sweep Sequencer

This block sequences a multi-channel analog-to-digital converter through a group of channels that always begins at channel 0. The sweep runs in two phases, each opened by a falling edge on an external trigger input. The first edge converts channel 0 and nothing else. The block then waits. A later falling edge starts channel 1, and every remaining channel of the group follows back to back without any further trigger.

The converter is abstract. For each conversion the block issues a one-cycle start strobe together with a channel index. The converter answers with a one-cycle done strobe and a result word, and the block stores that word in the channel's own result slot. A registered read port returns any slot. When the last channel of the group finishes, the block pulses a sweep-complete interrupt and goes back to idle. The next falling edge then counts as a new channel-0 start.

A software enable bit permits operation. Clearing it halts the block at once. Setting it never starts a conversion by itself. The trigger input is brought into the clock domain by a two-flop synchronizer, so a low pulse shorter than one clock period can be missed.

Top module: `adc_sweep_seq`

## Requirements
- R1: Channels are converted one at a time and in ascending order. Each conversion begins with `conv_start` high for exactly one cycle, while `conv_ch` holds the channel number.
- R2: The result that arrives with `conv_done` for an accepted conversion is stored in that channel's slot. Driving `rd_ch` at rising edge k makes `rd_data` show that slot's content after edge k.
- R3: `grp_sel` selects the group size: 0 gives channels 0..1, 1 gives 0..3, 2 gives 0..5 and 3 gives 0..7. A complete sweep issues exactly that many start strobes.
- R4: Trigger synchronization. If `trig_n` was sampled high at rising edge k-1 and low at edge k, a falling edge is recognized, and an idle, enabled block raises `conv_start` after edge k+2.
- R5: A falling edge in idle starts channel 0 only. After channel 0 is done, the block waits in state 2 and issues no start until another falling edge arrives.
- R6: A falling edge in the waiting state starts channel 1. Each later channel's start strobe follows in the cycle after the previous channel's done.
- R7: A falling edge is ignored if it arrives while channel 0 is converting or while the sweep of channels 1..last is running.
- R8: `sweep_irq` pulses for one cycle when the last channel's done is accepted, and the block returns to idle in that same cycle. The next falling edge starts a fresh channel-0 conversion.
- R9: While `enable` is 0, the next state is idle and no start is issued. A done that arrives during a halt is discarded, and trigger edges are ignored. Holding `enable` at 1 without a trigger starts nothing.
- R10: `state_o` encodes 0 = idle, 1 = converting channel 0, 2 = waiting for the second trigger, 3 = sweeping. After reset the block is idle, with `conv_start` and `sweep_irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Software run permit; 0 halts the block |
| grp_sel | input | 2 | Group size select (2/4/6/8 channels) |
| trig_n | input | 1 | Asynchronous trigger input, acts on its falling edge |
| conv_start | output | 1 | One-cycle start strobe to the converter |
| conv_ch | output | 3 | Channel index for the converter |
| conv_done | input | 1 | One-cycle done strobe from the converter |
| conv_result | input | 10 | Conversion result, valid together with conv_done |
| rd_ch | input | 3 | Result slot to read |
| rd_data | output | 10 | Registered read data |
| sweep_irq | output | 1 | One-cycle sweep-complete interrupt |
| state_o | output | 2 | Phase status (see R10) |

## Verification
The bench fires extra trigger edges while channel 0 is converting and again in the middle of the sweep. A design that failed to ignore them would restart the sweep or skip channels, so the start count and the channel sequence would no longer match the model. It also drops `enable` with a conversion still in flight and lets that conversion's done arrive after the halt. A design that still accepted the done would overwrite a result slot or step on to the next channel. The bench runs all four group sizes and checks that exactly the right number of start strobes and a single interrupt appear. It also measures the trigger-to-start latency, which would change if the synchronizer stages were miscounted.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FIRST = 2'd1,
    PH_HOLD  = 2'd2,
    PH_SWEEP = 2'd3
  } phase_t;
endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_n,
  output logic fall
);
  // STAGES synchronizer flops plus one history flop for edge compare
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= 1'b1;
    else     pipe[0] <= trig_n;
  end

  for (genvar i = 1; i <= STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[i] <= 1'b1;
      else     pipe[i] <= pipe[i-1];
    end
  end

  assign fall = pipe[STAGES] & ~pipe[STAGES-1];
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int DEPTH = 8,
  parameter int DW    = 10,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/adc_sweep_fsm.sv
module adc_sweep_fsm
  import adc_seq_pkg::*;
#(
  parameter int NCH  = 8,
  localparam int CW  = $clog2(NCH),
  localparam int GW  = CW - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic [GW-1:0] grp_sel,
  input  logic          fall,
  input  logic          conv_done,
  output phase_t        phase,
  output logic          conv_start,
  output logic [CW-1:0] conv_ch,
  output logic          sweep_irq,
  output logic          wr_en
);
  logic [CW-1:0] last_ch;
  logic          accept;

  assign last_ch = {grp_sel, 1'b1};
  assign accept  = enable && conv_done &&
                   (phase == PH_FIRST || phase == PH_SWEEP);
  assign wr_en   = accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      conv_start <= 1'b0;
      conv_ch    <= '0;
      sweep_irq  <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      sweep_irq  <= 1'b0;
      if (!enable) begin
        phase <= PH_IDLE;
      end else begin
        unique case (phase)
          PH_IDLE: if (fall) begin
            phase      <= PH_FIRST;
            conv_ch    <= '0;
            conv_start <= 1'b1;
          end
          PH_FIRST: if (accept) phase <= PH_HOLD;
          PH_HOLD: if (fall) begin
            phase      <= PH_SWEEP;
            conv_ch    <= CW'(1);
            conv_start <= 1'b1;
          end
          PH_SWEEP: if (accept) begin
            if (conv_ch == last_ch) begin
              phase     <= PH_IDLE;
              sweep_irq <= 1'b1;
            end else begin
              conv_ch    <= conv_ch + CW'(1);
              conv_start <= 1'b1;
            end
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_sweep_seq.sv
module adc_sweep_seq
  import adc_seq_pkg::*;
#(
  parameter int NCH         = 8,
  parameter int RES_W       = 10,
  parameter int SYNC_STAGES = 2,
  localparam int CW         = $clog2(NCH),
  localparam int GW         = CW - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [GW-1:0]    grp_sel,
  input  logic             trig_n,
  output logic             conv_start,
  output logic [CW-1:0]    conv_ch,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  input  logic [CW-1:0]    rd_ch,
  output logic [RES_W-1:0] rd_data,
  output logic             sweep_irq,
  output logic [1:0]       state_o
);
  logic   fall;
  logic   wr_en;
  phase_t phase;

  adc_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .trig_n(trig_n), .fall(fall)
  );

  adc_sweep_fsm #(.NCH(NCH)) u_fsm (
    .clk(clk), .rst(rst), .enable(enable), .grp_sel(grp_sel),
    .fall(fall), .conv_done(conv_done), .phase(phase),
    .conv_start(conv_start), .conv_ch(conv_ch),
    .sweep_irq(sweep_irq), .wr_en(wr_en)
  );

  adc_result_bank #(.DEPTH(NCH), .DW(RES_W)) u_bank (
    .clk(clk), .we(wr_en), .waddr(conv_ch), .wdata(conv_result),
    .raddr(rd_ch), .rdata(rd_data)
  );

  assign state_o = phase;
endmodule

// File: rtl/adc_sweep_seq_chk.sv
module adc_sweep_seq_chk #(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          enable,
  input logic          conv_start,
  input logic [CW-1:0] conv_ch,
  input logic          sweep_irq,
  input logic [1:0]    state_o
);
  // start only in a converting phase, channel 0 only in the first phase
  p_start_phase_r1: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> ((state_o == 2'd1 && conv_ch == '0) || state_o == 2'd3));

  p_ascend_r1: assert property (@(posedge clk) disable iff (rst)
    (conv_start && state_o == 2'd3 && $past(state_o) == 2'd3)
      |-> conv_ch == $past(conv_ch) + CW'(1));

  p_hold_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    state_o == 2'd2 |-> !conv_start);

  p_irq_idle_r8: assert property (@(posedge clk) disable iff (rst)
    sweep_irq |-> (state_o == 2'd0 && $past(state_o) == 2'd3));

  p_halt_r9: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (state_o == 2'd0 && !conv_start));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    state_o == 2'd0 |-> !conv_start);
endmodule

bind adc_sweep_seq adc_sweep_seq_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .conv_start(conv_start),
  .conv_ch(conv_ch), .sweep_irq(sweep_irq), .state_o(state_o)
);

// File: tb/adc_sweep_seq_test.sv
module adc_sweep_seq_test;
  localparam int LAT = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b0;
  logic [1:0] grp_sel = 2'd0;
  logic       trig_n = 1'b1;
  logic       conv_done = 1'b0;
  logic [9:0] conv_result = '0;
  logic [2:0] rd_ch = '0;
  logic       conv_start, sweep_irq;
  logic [2:0] conv_ch;
  logic [9:0] rd_data;
  logic [1:0] state_o;

  int n_tests = 0, n_fail = 0;
  int n_start = 0, n_irq = 0, n_done = 0, cyc = 0;

  always #10 clk = ~clk;

  adc_sweep_seq uut (
    .clk(clk), .rst(rst), .enable(enable), .grp_sel(grp_sel),
    .trig_n(trig_n), .conv_start(conv_start), .conv_ch(conv_ch),
    .conv_done(conv_done), .conv_result(conv_result), .rd_ch(rd_ch),
    .rd_data(rd_data), .sweep_irq(sweep_irq), .state_o(state_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // converter model: done LAT cycles after a start
  int cnt = 0;
  always @(negedge clk) begin
    conv_done = 1'b0;
    if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin
        conv_done   = 1'b1;
        n_done++;
        conv_result = 10'(int'(conv_ch) * 37 + n_done * 5);
      end
    end
    if (conv_start) cnt = LAT;
  end

  // behavioural reference model
  bit hist[$];
  int m_state, m_ch, mem[8];
  bit m_start, m_irq, m_rd_ok, valid[8];
  int m_rd;
  always @(posedge clk) begin
    bit f;
    if (rst) begin
      m_state = 0; m_start = 0; m_ch = 0; m_irq = 0; m_rd_ok = 0;
      hist = '{1'b1, 1'b1, 1'b1};
    end else begin
      f = hist[2] && !hist[1];
      hist.push_front(trig_n);
      void'(hist.pop_back());
      m_rd_ok = valid[rd_ch];
      m_rd = mem[rd_ch];
      m_start = 0; m_irq = 0;
      if (!enable) m_state = 0;
      else begin
        case (m_state)
          0: if (f) begin m_state = 1; m_ch = 0; m_start = 1; end
          1: if (conv_done) begin
               mem[0] = int'(conv_result); valid[0] = 1; m_state = 2;
             end
          2: if (f) begin m_state = 3; m_ch = 1; m_start = 1; end
          default: if (conv_done) begin
               mem[m_ch] = int'(conv_result); valid[m_ch] = 1;
               if (m_ch == 2 * int'(grp_sel) + 1) begin m_state = 0; m_irq = 1; end
               else begin m_ch++; m_start = 1; end
             end
        endcase
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      chk("R1 conv_start", int'(conv_start), int'(m_start));
      chk("R1 conv_ch", int'(conv_ch), m_ch);
      chk("R5 state_o", int'(state_o), m_state);
      chk("R8 sweep_irq", int'(sweep_irq), int'(m_irq));
      if (m_rd_ok) chk("R2 rd_data", int'(rd_data), m_rd);
      if (conv_start) n_start++;
      if (sweep_irq) n_irq++;
    end
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic pulse(input int lo);
    @(negedge clk) trig_n = 1'b0;
    repeat (lo) @(negedge clk);
    trig_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_state(input int s);
    for (int i = 0; i < 400; i++) begin
      if (int'(state_o) == s) return;
      @(negedge clk);
    end
    chk("R5 wait_state timeout", int'(state_o), s);
  endtask

  task automatic full_sweep(input int g);
    int s0, i0;
    grp_sel = 2'(g);
    s0 = n_start; i0 = n_irq;
    pulse(2);
    wait_state(2);
    chk("R5 only ch0 before second edge", n_start - s0, 1);
    repeat (5) @(negedge clk);
    chk("R5 hold without trigger", int'(state_o), 2);
    pulse(2);
    wait_state(3);
    pulse(2);                       // mid-sweep edge, must be ignored (R7)
    wait_state(0);
    repeat (2) @(negedge clk);
    chk("R3 starts per sweep", n_start - s0, 2 * g + 2);
    chk("R8 one irq per sweep", n_irq - i0, 1);
  endtask

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    chk("R10 reset state", int'(state_o), 0);
    chk("R10 reset start", int'(conv_start), 0);
    chk("R10 reset irq", int'(sweep_irq), 0);
    rst = 1'b0;
    enable = 1'b1;
    repeat (12) @(negedge clk);
    chk("R9 enable alone starts nothing", n_start, 0);

    // R4 latency: low driven before edge k, start after edge k+2
    grp_sel = 2'd1;
    @(negedge clk) trig_n = 1'b0;
    @(negedge clk) chk("R4 no start after k", int'(conv_start), 0);
    @(negedge clk) chk("R4 no start after k+1", int'(conv_start), 0);
    @(negedge clk) chk("R4 start after k+2", int'(conv_start), 1);
    trig_n = 1'b1;
    @(negedge clk) trig_n = 1'b0;   // edge during channel-0 conversion (R7)
    repeat (2) @(negedge clk) trig_n = 1'b1;
    wait_state(2);
    chk("R7 edge during ch0 ignored", n_start, 1);
    pulse(2);
    wait_state(0);
    repeat (2) @(negedge clk);
    chk("R6 group of four finished", n_start, 4);

    // R2 readback of all four slots via the model
    for (int c = 0; c < 4; c++) begin
      @(negedge clk) rd_ch = 3'(c);
      @(negedge clk);
      chk("R2 slot written", int'(valid[c]), 1);
    end

    full_sweep(3);
    full_sweep(0);
    full_sweep(2);

    // R9 halt during sweep, done arrives after halt
    grp_sel = 2'd3;
    pulse(2); wait_state(2); pulse(2); wait_state(3);
    repeat (3) @(negedge clk);
    enable = 1'b0;
    @(negedge clk) chk("R9 halt to idle", int'(state_o), 0);
    s0 = n_start;
    pulse(2);
    repeat (10) @(negedge clk);
    chk("R9 edges ignored while halted", n_start - s0, 0);
    enable = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 re-enable starts nothing", n_start - s0, 0);
    full_sweep(1);                  // fresh start after halt (R8)

    for (int c = 0; c < 8; c++) begin
      @(negedge clk) rd_ch = 3'(c);
    end
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule